// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block is the standard 64-byte configuration header of one PCI function. It sits behind a simple register port. A request carries a byte offset, an access size of one, two or four bytes, write data and a write flag. The block answers every request exactly one cycle later with a valid strobe, read data and an error flag. Identification values, reset contents and the size of each of the six base address registers are fixed by parameters. Software can change the command register, cache line size, latency timer, interrupt line, the six base address registers and the expansion ROM base.

Each base address register supports the usual sizing handshake. Writing all ones makes the register read back a size mask, and its low type bits are kept. A normal write with non-zero address bits records a decode base. The base is offset by an I/O window or a memory window, depending on the register's type bit. The block drives that base on `bar_base`, and sets a sticky enable on `bar_en`, so the surrounding address decoder can claim the range. Each size parameter must be zero or a power of two, and any other value stops elaboration.

Top module: `pci_cfg_header`

## Requirements
- R1: After reset, every header field holds its parameter value, `bar_en` is all zero, `bar_base` is zero and `rsp_valid` is low.
- R2: A request accepted in one cycle produces exactly one `rsp_valid` pulse in the next cycle. No response appears without a request. Read data is right-justified. A write response carries zero data.
- R3: `req_size` 0, 1 and 2 read 1, 2 and 4 bytes. Byte k of the data is header byte offset+k, so the order is little-endian. The header layout is the type-0 map: vendor 0x00, device 0x02, command 0x04, status 0x06, revision 0x08, class 0x09-0x0B, cache line 0x0C, latency 0x0D, header type 0x0E, self-test 0x0F, BARs 0x10-0x24, card info 0x28, subsystem 0x2C/0x2E, ROM 0x30, interrupt line 0x3C, interrupt pin 0x3D, min grant 0x3E, max latency 0x3F. Unused offsets read as zero.
- R4: A read with `req_size`=3, or one whose bytes run past offset 0x3F, returns zero data with `rsp_err` set.
- R5: A byte write to 0x0C, 0x0D or 0x3C replaces, respectively, the cache line size, the latency timer or the interrupt line with `req_wdata[7:0]`.
- R6: A byte write to 0x08-0x0B or 0x3D-0x3F changes nothing and raises no error.
- R7: A word or halfword write to 0x04 replaces the command register with `req_wdata[15:0]` and leaves status unchanged. A halfword write to 0x0C loads the cache line size from bits 7:0 and the latency timer from bits 15:8.
- R8: A word write of 0xFFFFFFFF to a BAR makes it read ~(size-1) in its address bits, with its type bits kept. A BAR whose size is zero then reads only its type bits.
- R9: Any other word write to a BAR keeps the old low type bits and stores the data in the remaining bits. Two bits are kept when bit 0 is 1 (I/O), four otherwise (memory).
- R10: A non-sizing BAR write with non-zero address bits sets `bar_base` to those bits plus `IO_WIN` or `MEM_WIN`, and sets that BAR's `bar_en`. The enable stays set. A write with zero address bits leaves base and enable alone.
- R11: A word write of 0xFFFFFFFE to 0x30 makes the ROM base read 0xFFFFFFFF. Any other word write there is stored unchanged.
- R12: Every other write is ignored: any offset and width not listed above, `req_size`=3, and offsets at or above 0x40. Each such write sets `rsp_err` in its response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into configuration space |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 = word, 3 = invalid |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Right-justified read data |
| rsp_err | output | 1 | Request was rejected or ignored as illegal |
| bar_base | output | 192 | Decoded base of BAR i in bits 32i+31:32i |
| bar_en | output | 6 | BAR i has a programmed decode range |

## Verification
A corrupted field shows on the read port in the response cycle that follows the next read of its offset. The port can read any byte alignment, so a bad byte lane or a wrong byte order also shows there. A wrong BAR type mask or base offset shows at once, on `bar_base` and `bar_en`, in the cycle after the write that caused it. Under sizing it also shows as wrong low bits in the read-back value. The bench keeps a full byte model of the header. After every request it compares the response and all six decode outputs with that model, so a fault is caught in the cycle it reaches the ports.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  localparam int NUM_BARS   = 6;
  localparam int HDR_BYTES  = 64;
  localparam int HDR_BITS   = HDR_BYTES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  // Low bits that a BAR keeps across writes, chosen by its type bit.
  function automatic logic [31:0] bar_keep_mask(input logic [31:0] old_val);
    return old_val[0] ? 32'h0000_0003 : 32'h0000_000F;
  endfunction

  // Address bits a write proposes: size mask when sizing, else the masked data.
  function automatic logic [31:0] bar_addr_bits(input logic [31:0] old_val,
                                                input logic [31:0] wdata,
                                                input logic [31:0] size);
    if (wdata == 32'hFFFF_FFFF) return ~(size - 32'd1);
    return wdata & ~bar_keep_mask(old_val);
  endfunction

  function automatic logic [31:0] bar_merge(input logic [31:0] old_val,
                                            input logic [31:0] addr_bits);
    logic [31:0] keep;
    keep = bar_keep_mask(old_val);
    return (addr_bits & ~keep) | (old_val & keep);
  endfunction

  function automatic logic [31:0] rom_next(input logic [31:0] wdata);
    return (wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wdata;
  endfunction

  // Little-endian extraction of 1, 2 or 4 bytes starting at a byte offset.
  function automatic logic [31:0] rd_extract(input logic [HDR_BITS-1:0] img,
                                             input logic [5:0] off,
                                             input logic [1:0] size);
    logic [HDR_BITS-1:0] sh;
    sh = img >> {off, 3'b000};
    case (size)
      SZ_BYTE: return {24'h0, sh[7:0]};
      SZ_HALF: return {16'h0, sh[15:0]};
      default: return sh[31:0];
    endcase
  endfunction

endpackage

// File: rtl/pcfg_decode.sv
module pcfg_decode
  import pcfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [5:0]        off,
  output logic              cmd_we,
  output logic              cls_we,
  output logic              lat_we,
  output logic              lat_hi,
  output logic              intl_we,
  output logic              rom_we,
  output logic [NUM_BARS-1:0] bar_we,
  output logic              rd_bad,
  output logic              wr_bad
);
  localparam int HI_W = ADDR_W - 6;

  logic       in_range;
  logic [6:0] span;
  logic       wr_ok;
  logic       wr_req;

  assign off      = addr[5:0];
  assign in_range = (addr[ADDR_W-1:6] == HI_W'(0));
  assign span     = {1'b0, off} + (7'd1 << size);
  assign wr_req   = valid && write && in_range;
  assign rd_bad   = valid && !write &&
                    (!in_range || size == SZ_BAD || span > 7'd64);
  assign wr_bad   = valid && write && !wr_ok;

  always_comb begin
    cmd_we  = 1'b0;
    cls_we  = 1'b0;
    lat_we  = 1'b0;
    lat_hi  = 1'b0;
    intl_we = 1'b0;
    rom_we  = 1'b0;
    bar_we  = '0;
    wr_ok   = 1'b0;
    if (wr_req) begin
      case (size)
        SZ_BYTE: begin
          case (off)
            6'h0C: begin cls_we  = 1'b1; wr_ok = 1'b1; end
            6'h0D: begin lat_we  = 1'b1; wr_ok = 1'b1; end
            6'h3C: begin intl_we = 1'b1; wr_ok = 1'b1; end
            6'h08, 6'h09, 6'h0A, 6'h0B,
            6'h3D, 6'h3E, 6'h3F: wr_ok = 1'b1;
            default: wr_ok = 1'b0;
          endcase
        end
        SZ_HALF: begin
          if (off == 6'h04) begin
            cmd_we = 1'b1;
            wr_ok  = 1'b1;
          end else if (off == 6'h0C) begin
            cls_we = 1'b1;
            lat_we = 1'b1;
            lat_hi = 1'b1;
            wr_ok  = 1'b1;
          end
        end
        SZ_WORD: begin
          if (off == 6'h04) begin
            cmd_we = 1'b1;
            wr_ok  = 1'b1;
          end else if (off == 6'h30) begin
            rom_we = 1'b1;
            wr_ok  = 1'b1;
          end
          for (int i = 0; i < NUM_BARS; i++) begin
            if (off == 6'(16 + 4 * i)) begin
              bar_we[i] = 1'b1;
              wr_ok     = 1'b1;
            end
          end
        end
        default: wr_ok = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pcfg_bar.sv
module pcfg_bar
  import pcfg_pkg::*;
#(
  parameter logic [31:0] SIZE    = 32'h0000_1000,
  parameter logic [31:0] INIT    = 32'h0000_0000,
  parameter logic [31:0] IO_WIN  = 32'h0001_0000,
  parameter logic [31:0] MEM_WIN = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] value,
  output logic [31:0] base,
  output logic        en
);
  localparam bit SIZE_OK = ((SIZE & (SIZE - 32'd1)) == 32'd0);

  generate
    if (!SIZE_OK) begin : g_size_check
      $error("pcfg_bar: SIZE must be zero or a power of two");
    end
  endgenerate

  logic [31:0] addr_bits;
  logic        sizing;
  logic        take_base;

  assign sizing    = (wdata == 32'hFFFF_FFFF);
  assign addr_bits = bar_addr_bits(value, wdata, SIZE);
  assign take_base = we && !sizing && (addr_bits != 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= INIT;
      base  <= 32'd0;
      en    <= 1'b0;
    end else begin
      if (we) value <= bar_merge(value, addr_bits);
      if (take_base) begin
        base <= addr_bits + (value[0] ? IO_WIN : MEM_WIN);
        en   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pcfg_pkg::*;
#(
  parameter int           ADDR_W      = 8,
  parameter logic [15:0]  VENDOR_ID   = 16'h1A2B,
  parameter logic [15:0]  DEVICE_ID   = 16'h0C3D,
  parameter logic [15:0]  CMD_INIT    = 16'h0000,
  parameter logic [15:0]  STATUS_INIT = 16'h0290,
  parameter logic [7:0]   REV_ID      = 8'h03,
  parameter logic [23:0]  CLASS_CODE  = 24'h020000,
  parameter logic [7:0]   CLS_INIT    = 8'h00,
  parameter logic [7:0]   LAT_INIT    = 8'h00,
  parameter logic [7:0]   HDR_TYPE    = 8'h00,
  parameter logic [7:0]   BIST_INIT   = 8'h00,
  parameter logic [31:0]  CIS_PTR     = 32'h0000_0000,
  parameter logic [15:0]  SUBSYS_VID  = 16'h1A2B,
  parameter logic [15:0]  SUBSYS_ID   = 16'h0001,
  parameter logic [31:0]  ROM_INIT    = 32'h0000_0000,
  parameter logic [7:0]   INTL_INIT   = 8'h0A,
  parameter logic [7:0]   INT_PIN     = 8'h01,
  parameter logic [7:0]   MIN_GNT     = 8'h10,
  parameter logic [7:0]   MAX_LAT     = 8'h20,
  parameter logic [32*6-1:0] BAR_INIT = {32'h0, 32'h1, 32'h8, 32'h0, 32'h1, 32'h0},
  parameter logic [32*6-1:0] BAR_SIZE = {32'h0, 32'h20, 32'h0010_0000,
                                         32'h0, 32'h100, 32'h1000},
  parameter logic [31:0]  IO_WIN      = 32'h0001_0000,
  parameter logic [31:0]  MEM_WIN     = 32'h8000_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  output logic                   rsp_err,
  output logic [32*6-1:0]        bar_base,
  output logic [5:0]             bar_en
);
  localparam int BAR_BITS = 32 * NUM_BARS;

  // Named internal events, visible to the bound checker.
  logic [5:0]          off;
  logic                cmd_we, cls_we, lat_we, lat_hi, intl_we, rom_we;
  logic [NUM_BARS-1:0] bar_we;
  logic                rd_bad, wr_bad;
  logic [BAR_BITS-1:0] bar_val;
  logic [HDR_BITS-1:0] img;

  logic [15:0] cmd_q;
  logic [7:0]  cls_q, lat_q, intl_q;
  logic [31:0] rom_q;

  pcfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid  (req_valid),
    .write  (req_write),
    .addr   (req_addr),
    .size   (req_size),
    .off    (off),
    .cmd_we (cmd_we),
    .cls_we (cls_we),
    .lat_we (lat_we),
    .lat_hi (lat_hi),
    .intl_we(intl_we),
    .rom_we (rom_we),
    .bar_we (bar_we),
    .rd_bad (rd_bad),
    .wr_bad (wr_bad)
  );

  generate
    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      pcfg_bar #(
        .SIZE   (BAR_SIZE[32*i +: 32]),
        .INIT   (BAR_INIT[32*i +: 32]),
        .IO_WIN (IO_WIN),
        .MEM_WIN(MEM_WIN)
      ) u_bar (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bar_we[i]),
        .wdata(req_wdata),
        .value(bar_val[32*i +: 32]),
        .base (bar_base[32*i +: 32]),
        .en   (bar_en[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_INIT;
      cls_q  <= CLS_INIT;
      lat_q  <= LAT_INIT;
      intl_q <= INTL_INIT;
      rom_q  <= ROM_INIT;
    end else begin
      if (cmd_we)  cmd_q  <= req_wdata[15:0];
      if (cls_we)  cls_q  <= req_wdata[7:0];
      if (lat_we)  lat_q  <= lat_hi ? req_wdata[15:8] : req_wdata[7:0];
      if (intl_we) intl_q <= req_wdata[7:0];
      if (rom_we)  rom_q  <= rom_next(req_wdata);
    end
  end

  // Header image, one dword per 32 bits, byte 0 in the low lane.
  always_comb begin
    img           = '0;
    img[0   +: 32] = {DEVICE_ID, VENDOR_ID};
    img[32  +: 32] = {STATUS_INIT, cmd_q};
    img[64  +: 32] = {CLASS_CODE, REV_ID};
    img[96  +: 32] = {BIST_INIT, HDR_TYPE, lat_q, cls_q};
    img[128 +: BAR_BITS] = bar_val;
    img[320 +: 32] = CIS_PTR;
    img[352 +: 32] = {SUBSYS_ID, SUBSYS_VID};
    img[384 +: 32] = rom_q;
    img[480 +: 32] = {MAX_LAT, MIN_GNT, INT_PIN, intl_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'd0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= rd_bad || wr_bad;
      rsp_rdata <= (req_valid && !req_write && !rd_bad)
                   ? rd_extract(img, off, req_size) : 32'd0;
    end
  end
endmodule

// File: rtl/pcfg_header_chk.sv
module pcfg_header_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_write,
  input logic [1:0]   req_size,
  input logic         rsp_valid,
  input logic         rsp_err,
  input logic [5:0]   bar_en,
  input logic [191:0] bar_val
);
  logic [11:0] type_bits;
  always_comb begin
    for (int i = 0; i < 6; i++) type_bits[2*i +: 2] = bar_val[32*i +: 2];
  end

  a_r1_en_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bar_en == 6'd0));

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r4_bad_size_read_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd3) |=> rsp_err);

  a_r12_bad_size_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == 2'd3) |=> rsp_err);

  a_r12_err_only_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  a_r9_type_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(type_bits));

  a_r10_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bar_en & $past(bar_en)) == $past(bar_en)));

  a_r10_en_needs_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_en != $past(bar_en)) |-> $past(req_valid && req_write && req_size == 2'd2));
endmodule

bind pci_cfg_header pcfg_header_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_size (req_size),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .bar_en   (bar_en),
  .bar_val  (bar_val)
);

// File: tb/tb_pci_cfg_header.sv
`timescale 1ns/1ps
module tb_pci_cfg_header;
  // Values mirror the design defaults.
  localparam logic [15:0] VID = 16'h1A2B, DID = 16'h0C3D, STS = 16'h0290;
  localparam logic [31:0] IOW = 32'h0001_0000, MEMW = 32'h8000_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]   req_addr = 8'd0;
  logic [1:0]   req_size = 2'd0;
  logic [31:0]  req_wdata = 32'd0;
  logic         rsp_valid, rsp_err;
  logic [31:0]  rsp_rdata;
  logic [191:0] bar_base;
  logic [5:0]   bar_en;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pci_cfg_header dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bar_base(bar_base), .bar_en(bar_en)
  );

  // Bench model of the writable state.
  logic [15:0] m_cmd;
  logic [7:0]  m_cls, m_lat, m_intl;
  logic [31:0] m_rom;
  logic [31:0] m_bar [6];
  logic [31:0] m_base[6];
  bit          m_en  [6];
  logic [31:0] m_size[6];
  logic [7:0]  mimg  [64];

  task automatic model_reset();
    m_cmd = 16'h0; m_cls = 8'h0; m_lat = 8'h0; m_intl = 8'h0A; m_rom = 32'h0;
    m_bar[0] = 32'h0; m_bar[1] = 32'h1; m_bar[2] = 32'h0;
    m_bar[3] = 32'h8; m_bar[4] = 32'h1; m_bar[5] = 32'h0;
    m_size[0] = 32'h1000; m_size[1] = 32'h100; m_size[2] = 32'h0;
    m_size[3] = 32'h0010_0000; m_size[4] = 32'h20; m_size[5] = 32'h0;
    for (int k = 0; k < 6; k++) begin m_base[k] = 32'h0; m_en[k] = 1'b0; end
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mimg[a + k] = v[8*k +: 8];
  endtask

  task automatic build_img();
    for (int k = 0; k < 64; k++) mimg[k] = 8'h00;
    put32(0, {DID, VID});
    put32(4, {STS, m_cmd});
    mimg[8] = 8'h03; mimg[9] = 8'h00; mimg[10] = 8'h00; mimg[11] = 8'h02;
    mimg[12] = m_cls; mimg[13] = m_lat;
    for (int k = 0; k < 6; k++) put32(16 + 4 * k, m_bar[k]);
    put32(44, {16'h0001, 16'h1A2B});
    put32(48, m_rom);
    mimg[60] = m_intl; mimg[61] = 8'h01; mimg[62] = 8'h10; mimg[63] = 8'h20;
  endtask

  function automatic bit exp_rd_err(input logic [1:0] sz, input int a);
    if (sz == 2'd3) return 1'b1;
    return (a + (1 << sz)) > 64;
  endfunction

  task automatic model_read(input logic [1:0] sz, input int a, output logic [31:0] r);
    build_img();
    r = 32'h0;
    for (int k = 0; k < (1 << sz); k++) r[8*k +: 8] = mimg[a + k];
  endtask

  task automatic model_write(input logic [1:0] sz, input int a, input logic [31:0] d,
                             output bit err);
    err = 1'b1;
    if (a < 64) begin
      if (sz == 2'd0) begin
        if (a == 12) begin m_cls = d[7:0]; err = 1'b0; end
        else if (a == 13) begin m_lat = d[7:0]; err = 1'b0; end
        else if (a == 60) begin m_intl = d[7:0]; err = 1'b0; end
        else if ((a >= 8 && a <= 11) || (a >= 61 && a <= 63)) err = 1'b0;
      end else if (sz == 2'd1) begin
        if (a == 4) begin m_cmd = d[15:0]; err = 1'b0; end
        else if (a == 12) begin m_cls = d[7:0]; m_lat = d[15:8]; err = 1'b0; end
      end else if (sz == 2'd2) begin
        if (a == 4) begin m_cmd = d[15:0]; err = 1'b0; end
        else if (a == 48) begin
          m_rom = (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d; err = 1'b0;
        end else if (a >= 16 && a <= 36 && (a % 4) == 0) begin
          int k;
          logic [31:0] keep, av;
          k = (a - 16) / 4;
          keep = m_bar[k][0] ? 32'h3 : 32'hF;
          if (d == 32'hFFFF_FFFF) av = 32'h0 - m_size[k];
          else begin
            av = d & ~keep;
            if (av != 32'h0) begin
              m_base[k] = av + (m_bar[k][0] ? IOW : MEMW);
              m_en[k] = 1'b1;
            end
          end
          m_bar[k] = (av & ~keep) | (m_bar[k] & keep);
          err = 1'b0;
        end
      end
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_bars(input string tag);
    for (int k = 0; k < 6; k++) begin
      chk(tag, "bar_base", bar_base[32*k +: 32], m_base[k]);
      chk(tag, "bar_en", {31'h0, bar_en[k]}, {31'h0, m_en[k]});
    end
  endtask

  // One request; inputs driven away from the clock edge, response sampled one cycle later.
  task automatic access(input bit w, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
    logic [31:0] er;
    bit ee;
    if (!w) begin
      ee = exp_rd_err(sz, int'(a));
      if (ee) er = 32'h0; else model_read(sz, int'(a), er);
    end else begin
      model_write(sz, int'(a), d, ee);
      er = 32'h0;
    end
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    chk(tag, "rsp_valid", {31'h0, rsp_valid}, 32'h1);
    chk(tag, "rsp_rdata", rsp_rdata, er);
    chk(tag, "rsp_err", {31'h0, rsp_err}, {31'h0, ee});
    req_valid = 1'b0;
    check_bars(tag);
  endtask

  task automatic read_lit(input logic [1:0] sz, input logic [7:0] a,
                          input logic [31:0] exp, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = a;
    @(negedge clk);
    chk(tag, "literal read", rsp_rdata, exp);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
    chk("R1", "bar_en", {26'h0, bar_en}, 32'h0);
    chk("R1", "bar_base", bar_base[31:0], 32'h0);
    for (int a = 0; a < 64; a += 4) access(1'b0, 2'd2, 8'(a), 32'h0, "R1");
    read_lit(2'd2, 8'h00, 32'h0C3D_1A2B, "R1");

    // R2: idle cycle gives no response
    @(negedge clk);
    chk("R2", "no response without request", {31'h0, rsp_valid}, 32'h0);

    // R3: unaligned and narrow reads
    read_lit(2'd1, 8'h01, 32'h0000_3D1A, "R3");
    read_lit(2'd0, 8'h3E, 32'h0000_0010, "R3");
    read_lit(2'd2, 8'h3C, 32'h2010_010A, "R3");
    access(1'b0, 2'd2, 8'h06, 32'h0, "R3");

    // R4: read errors
    access(1'b0, 2'd3, 8'h00, 32'h0, "R4");
    access(1'b0, 2'd2, 8'h3E, 32'h0, "R4");
    access(1'b0, 2'd0, 8'h40, 32'h0, "R4");

    // R5 / R6: byte writes
    access(1'b1, 2'd0, 8'h0C, 32'h0000_0040, "R5");
    access(1'b1, 2'd0, 8'h3C, 32'h0000_00B7, "R5");
    read_lit(2'd0, 8'h0C, 32'h0000_0040, "R5");
    access(1'b1, 2'd0, 8'h08, 32'h0000_00FF, "R6");
    access(1'b1, 2'd0, 8'h3D, 32'h0000_00FF, "R6");
    read_lit(2'd2, 8'h08, 32'h0200_0003, "R6");

    // R7: command writes
    access(1'b1, 2'd2, 8'h04, 32'hFFFF_1234, "R7");
    read_lit(2'd2, 8'h04, {STS, 16'h1234}, "R7");
    access(1'b1, 2'd1, 8'h0C, 32'h0000_5520, "R7");
    read_lit(2'd1, 8'h0C, 32'h0000_5520, "R7");

    // R8: sizing
    access(1'b1, 2'd2, 8'h10, 32'hFFFF_FFFF, "R8");
    read_lit(2'd2, 8'h10, 32'hFFFF_F000, "R8");
    access(1'b1, 2'd2, 8'h14, 32'hFFFF_FFFF, "R8");
    read_lit(2'd2, 8'h14, 32'hFFFF_FF01, "R8");
    access(1'b1, 2'd2, 8'h18, 32'hFFFF_FFFF, "R8");
    read_lit(2'd2, 8'h18, 32'h0000_0000, "R8");
    access(1'b1, 2'd2, 8'h1C, 32'hFFFF_FFFF, "R8");
    read_lit(2'd2, 8'h1C, 32'hFFF0_0008, "R8");

    // R9 / R10: programming
    access(1'b1, 2'd2, 8'h10, 32'h1234_567F, "R9");
    read_lit(2'd2, 8'h10, 32'h1234_5670, "R9");
    chk("R10", "bar0 base", bar_base[31:0], 32'h9234_5670);
    access(1'b1, 2'd2, 8'h14, 32'h0000_ABCE, "R10");
    chk("R10", "bar1 io base", bar_base[63:32], 32'h0001_ABCC);
    access(1'b1, 2'd2, 8'h24, 32'h0000_0007, "R10");
    chk("R10", "bar5 stays disabled", {31'h0, bar_en[5]}, 32'h0);

    // R11: ROM
    access(1'b1, 2'd2, 8'h30, 32'hFFFF_FFFE, "R11");
    read_lit(2'd2, 8'h30, 32'hFFFF_FFFF, "R11");
    access(1'b1, 2'd2, 8'h30, 32'h1234_5678, "R11");
    read_lit(2'd2, 8'h30, 32'h1234_5678, "R11");

    // R12: illegal writes
    access(1'b1, 2'd2, 8'h00, 32'hDEAD_BEEF, "R12");
    read_lit(2'd2, 8'h00, 32'h0C3D_1A2B, "R12");
    access(1'b1, 2'd0, 8'h04, 32'h0000_00AA, "R12");
    access(1'b1, 2'd3, 8'h0C, 32'h0000_00AA, "R12");
    access(1'b1, 2'd2, 8'h44, 32'h0000_00AA, "R12");

    // Constrained random traffic against the model
    for (int n = 0; n < 600; n++) begin
      bit w;
      logic [1:0] sz;
      logic [7:0] a;
      logic [31:0] d;
      int sel;
      string tag;
      w   = ($urandom % 2) == 1;
      sz  = 2'($urandom % 4);
      a   = 8'($urandom % 72);
      sel = $urandom % 8;
      if (w && ($urandom % 2) == 1) begin
        sz = 2'd2;
        a  = 8'(4 * ($urandom % 16));
      end
      d = (sel < 2) ? 32'hFFFF_FFFF : (sel == 2) ? 32'hFFFF_FFFE
        : (sel == 3) ? 32'h0 : $urandom;
      if (w) tag = (a >= 8'h10 && a <= 8'h24 && sz == 2'd2) ? "R9" : "R12";
      else   tag = exp_rd_err(sz, int'(a)) ? "R4" : "R3";
      access(w, sz, a, d, tag);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule